// File: doc/BRIEF.md
# Digit-Serial Ring Minimum Unit

This block finds the smallest of a set of 32-bit timestamps, one per node of a ring, without a parallel comparator tree. Each node presents its value one digit per cycle, most significant digit first. At every node, a small stage compares its own digit stream with the streams of its left and right ring neighbours and emits the stream of the smallest of the three values. It decides this one digit at a time by keeping a flag for each input that is still a candidate for the minimum.

Stages are stacked as pipeline levels. Each level takes the outputs of the level below as its three-input neighbourhood, so after L levels a node holds the minimum over 2L+1 consecutive nodes. With enough levels the window covers the whole ring. Every node then carries the global minimum, so reduction and broadcast happen in the same pass. The digit width is a parameter, and one value takes 32/DW digit cycles.

Top module: `ring_min_unit`

## Requirements
- R1: While reset is held, and for two cycles after it is released, `min_valid` and `min_first` are low and every digit of `min_dig` is zero.
- R2: At the first digit of a value, each stage outputs the smallest of its own digit and the digits of ring neighbours (i-1) mod NODES and (i+1) mod NODES. Digit i of a bus occupies bits [i*DW +: DW].
- R3: Digits are processed most significant first. An input whose digit is larger than the emitted digit stops being a candidate for the rest of that value, even if its later digits are smaller.
- R4: When inputs have the same digit, all of them remain candidates. Equal input streams produce that same stream at the output.
- R5: `dig_first` marks digit 0 of a value and makes all three inputs of every stage candidates again. Values may follow each other with no idle cycle between them.
- R6: `min_valid`, `min_first` and each output digit appear exactly LEVELS clock cycles after the matching input digit. `min_first` is only ever high together with `min_valid`.
- R7: After LEVELS levels, node i outputs the minimum of the 2*LEVELS+1 values at nodes i-LEVELS to i+LEVELS, taken modulo NODES. When 2*LEVELS+1 >= NODES, every node outputs the global minimum.
- R8: DW is one of 1, 2, 4 or 8. A 32-bit value is streamed as 32/DW digits, and the output digits rebuild the 32-bit minimum in the same order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| dig_valid | input | 1 | The input digits are valid this cycle |
| dig_first | input | 1 | This cycle carries the most significant digit of a new value |
| local_dig | input | NODES*DW | One digit per node; node i at bits [i*DW +: DW] |
| min_valid | output | 1 | The output digits are valid |
| min_first | output | 1 | The output digits are the most significant digit of a result |
| min_dig | output | NODES*DW | Minimum digit per node; node i at bits [i*DW +: DW] |

## Verification
The assertions assume that every value starts with a `dig_first` cycle and that its digits arrive in consecutive valid cycles. They also assume that no digits arrive while the internal reset is still held. Without these conditions the candidate flags, and the broadcast check that every node agrees, would have no meaning. The stimulus always starts a stream with `dig_first` and keeps `dig_valid` high for exactly 32/DW cycles per value, including back-to-back values. It sends the first digit only several cycles after reset has been released.

// File: rtl/rmu_pkg.sv
package rmu_pkg;
  localparam int VALUE_W = 32;

  function automatic int digits_per_value(input int dw);
    return VALUE_W / dw;
  endfunction
endpackage

// File: rtl/rmu_stage.sv
module rmu_stage #(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          first,
  input  logic [DW-1:0] dig_l,
  input  logic [DW-1:0] dig_c,
  input  logic [DW-1:0] dig_r,
  output logic [DW-1:0] dig_o
);
  logic [2:0]    cand_q, cand_d, live;
  logic [DW-1:0] dig_q, dig_d;
  logic [DW-1:0] d [3];

  // Next state: smallest digit among live candidates; survivors match it.
  always_comb begin
    d[0] = dig_l;
    d[1] = dig_c;
    d[2] = dig_r;
    live = first ? 3'b111 : cand_q;
    dig_d = '1;
    for (int k = 0; k < 3; k++) begin
      if (live[k] && (d[k] < dig_d)) dig_d = d[k];
    end
    for (int k = 0; k < 3; k++) begin
      cand_d[k] = live[k] && (d[k] == dig_d);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q <= 3'b111;
      dig_q  <= '0;
    end else if (en) begin
      cand_q <= cand_d;
      dig_q  <= dig_d;
    end
  end

  assign dig_o = dig_q;
endmodule

// File: rtl/rmu_level.sv
module rmu_level #(
  parameter int NODES = 8,
  parameter int DW    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                in_first,
  input  logic [NODES*DW-1:0] in_dig,
  output logic                out_valid,
  output logic                out_first,
  output logic [NODES*DW-1:0] out_dig
);
  logic valid_q, first_q, valid_d, first_d;

  for (genvar i = 0; i < NODES; i++) begin : g_node
    localparam int LEFT  = (i + NODES - 1) % NODES;
    localparam int RIGHT = (i + 1) % NODES;
    rmu_stage #(.DW(DW)) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (in_valid),
      .first (in_first),
      .dig_l (in_dig[LEFT*DW +: DW]),
      .dig_c (in_dig[i*DW +: DW]),
      .dig_r (in_dig[RIGHT*DW +: DW]),
      .dig_o (out_dig[i*DW +: DW])
    );
  end

  always_comb begin
    valid_d = in_valid;
    first_d = in_valid && in_first;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      first_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      first_q <= first_d;
    end
  end

  assign out_valid = valid_q;
  assign out_first = first_q;
endmodule

// File: rtl/ring_min_unit.sv
module ring_min_unit #(
  parameter int NODES  = 8,
  parameter int LEVELS = 4,
  parameter int DW     = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dig_valid,
  input  logic                dig_first,
  input  logic [NODES*DW-1:0] local_dig,
  output logic                min_valid,
  output logic                min_first,
  output logic [NODES*DW-1:0] min_dig
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [LEVELS:0]                lv_valid;
  logic [LEVELS:0]                lv_first;
  logic [LEVELS:0][NODES*DW-1:0]  lv_dig;

  assign lv_valid[0] = dig_valid;
  assign lv_first[0] = dig_first;
  assign lv_dig[0]   = local_dig;

  for (genvar l = 1; l <= LEVELS; l++) begin : g_level
    rmu_level #(.NODES(NODES), .DW(DW)) u_level (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .in_valid  (lv_valid[l-1]),
      .in_first  (lv_first[l-1]),
      .in_dig    (lv_dig[l-1]),
      .out_valid (lv_valid[l]),
      .out_first (lv_first[l]),
      .out_dig   (lv_dig[l])
    );
  end

  assign min_valid = lv_valid[LEVELS];
  assign min_first = lv_first[LEVELS];
  assign min_dig   = lv_dig[LEVELS];
endmodule

// File: rtl/rmu_checker.sv
module rmu_checker #(
  parameter int NODES  = 8,
  parameter int LEVELS = 4,
  parameter int DW     = 4
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic [LEVELS:0]                    lv_valid,
  input logic [LEVELS:0]                    lv_first,
  input logic [LEVELS:0][NODES*DW-1:0]      lv_dig
);
  initial begin
    a_r8_digit_width: assert (DW == 1 || DW == 2 || DW == 4 || DW == 8)
      else $error("R8: unsupported digit width %0d", DW);
  end

  for (genvar l = 1; l <= LEVELS; l++) begin : g_lv
    a_r6_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
      lv_valid[l] == $past(lv_valid[l-1]));
    a_r6_first_in_valid: assert property (@(posedge clk) disable iff (!rst_n)
      lv_first[l] |-> lv_valid[l]);
    for (genvar i = 0; i < NODES; i++) begin : g_nd
      localparam int LE = (i + NODES - 1) % NODES;
      localparam int RI = (i + 1) % NODES;
      a_r2_first_min: assert property (@(posedge clk) disable iff (!rst_n)
        (lv_valid[l-1] && lv_first[l-1]) |=>
          (lv_dig[l][i*DW +: DW] <= $past(lv_dig[l-1][LE*DW +: DW])) &&
          (lv_dig[l][i*DW +: DW] <= $past(lv_dig[l-1][i*DW +: DW])) &&
          (lv_dig[l][i*DW +: DW] <= $past(lv_dig[l-1][RI*DW +: DW])));
      a_r4_equal_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (lv_valid[l-1] && lv_first[l-1] &&
         lv_dig[l-1][LE*DW +: DW] == lv_dig[l-1][i*DW +: DW] &&
         lv_dig[l-1][RI*DW +: DW] == lv_dig[l-1][i*DW +: DW]) |=>
          lv_dig[l][i*DW +: DW] == $past(lv_dig[l-1][i*DW +: DW]));
    end
  end

  if (NODES <= 2*LEVELS + 1) begin : g_bcast
    for (genvar i = 1; i < NODES; i++) begin : g_nd
      a_r7_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
        lv_valid[LEVELS] |-> lv_dig[LEVELS][i*DW +: DW] == lv_dig[LEVELS][0 +: DW]);
    end
  end
endmodule

bind ring_min_unit rmu_checker #(.NODES(NODES), .LEVELS(LEVELS), .DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .lv_valid (lv_valid),
  .lv_first (lv_first),
  .lv_dig   (lv_dig)
);

// File: tb/sim_ring_min_unit.sv
`timescale 1ns/1ps
module sim_ring_min_unit;
  localparam int NODES = 8;
  localparam int LV0   = 4;
  localparam int LV1   = 1;
  localparam int DW    = 4;
  localparam int DIG   = 32 / DW;

  logic clk = 1'b0;
  logic rst_n;
  logic dig_valid, dig_first;
  logic [NODES*DW-1:0] local_dig;
  logic min_valid, min_first, mv1, mf1;
  logic [NODES*DW-1:0] min_dig, md1;

  always #2.5 clk = ~clk;

  ring_min_unit #(.NODES(NODES), .LEVELS(LV0), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .dig_valid(dig_valid), .dig_first(dig_first),
    .local_dig(local_dig), .min_valid(min_valid), .min_first(min_first), .min_dig(min_dig));

  ring_min_unit #(.NODES(NODES), .LEVELS(LV1), .DW(DW)) u1 (
    .clk(clk), .rst_n(rst_n), .dig_valid(dig_valid), .dig_first(dig_first),
    .local_dig(local_dig), .min_valid(mv1), .min_first(mf1), .min_dig(md1));

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] cur [2][NODES];
  logic [31:0] r0  [2][NODES];
  logic [31:0] r1  [2][NODES];
  int first_it0, first_it1;
  int firstbad;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] gmin(input int vi);
    logic [31:0] m = 32'hFFFF_FFFF;
    for (int n = 0; n < NODES; n++) if (cur[vi][n] < m) m = cur[vi][n];
    return m;
  endfunction

  function automatic logic [31:0] wmin(input int vi, input int n);
    logic [31:0] a = cur[vi][(n + NODES - 1) % NODES];
    logic [31:0] b = cur[vi][n];
    logic [31:0] c = cur[vi][(n + 1) % NODES];
    logic [31:0] m = (a < b) ? a : b;
    return (c < m) ? c : m;
  endfunction

  // Streams nv values back to back and collects both instances' outputs.
  task automatic stream(input int nv);
    int c0 = 0;
    int c1 = 0;
    first_it0 = -1;
    first_it1 = -1;
    firstbad  = 0;
    for (int j = 0; j < nv*DIG + LV0 + 2; j++) begin
      if (min_valid) begin
        if (c0 == 0) first_it0 = j;
        if (min_first != (c0 % DIG == 0)) firstbad++;
        for (int n = 0; n < NODES; n++)
          r0[c0/DIG][n] = {r0[c0/DIG][n][31-DW:0], min_dig[n*DW +: DW]};
        c0++;
      end
      if (mv1) begin
        if (c1 == 0) first_it1 = j;
        if (mf1 != (c1 % DIG == 0)) firstbad++;
        for (int n = 0; n < NODES; n++)
          r1[c1/DIG][n] = {r1[c1/DIG][n][31-DW:0], md1[n*DW +: DW]};
        c1++;
      end
      if (j < nv*DIG) begin
        dig_valid = 1'b1;
        dig_first = (j % DIG == 0);
        for (int n = 0; n < NODES; n++)
          local_dig[n*DW +: DW] = DW'(cur[j/DIG][n] >> (32 - ((j % DIG) + 1)*DW));
      end else begin
        dig_valid = 1'b0;
        dig_first = 1'b0;
      end
      @(negedge clk);
    end
  endtask

  task automatic verify(input int nv, input string tag);
    for (int vi = 0; vi < nv; vi++) begin
      for (int n = 0; n < NODES; n++) begin
        chk(r0[vi][n] == gmin(vi), {tag, " R7 global broadcast"}, r0[vi][n], gmin(vi));
        chk(r1[vi][n] == wmin(vi, n), {tag, " R2 three-node window"}, r1[vi][n], wmin(vi, n));
      end
    end
  endtask

  task automatic t_reset;
    chk(min_valid == 1'b0 && min_first == 1'b0, "R1 reset flags", {30'b0, min_valid, min_first}, 32'h0);
    chk(min_dig == '0, "R1 reset digits", min_dig, 32'h0);
  endtask

  task automatic t_spread;
    cur[0] = '{32'h8000_0000, 32'h7F00_1234, 32'hDEAD_BEEF, 32'h0F0F_0F0F,
               32'h1234_5678, 32'h0F0F_0F10, 32'hFFFF_0000, 32'h4000_0000};
    stream(1);
    verify(1, "spread R8");
    chk(first_it0 == LV0, "R6 latency level4", first_it0, LV0);
    chk(first_it1 == LV1, "R6 latency level1", first_it1, LV1);
    chk(firstbad == 0, "R6 first marker", firstbad, 0);
  endtask

  task automatic t_msb_first;
    // R3: node 3 wins on its top digit although its lower digits are all F.
    cur[0] = '{32'hF000_0000, 32'hF000_0001, 32'h2000_0000, 32'h1FFF_FFFF,
               32'hF000_0002, 32'h2000_0000, 32'hF111_1111, 32'hF000_0000};
    stream(1);
    verify(1, "R3 msb");
  endtask

  task automatic t_ties;
    // R4: long shared prefixes, one value a single unit smaller.
    cur[0] = '{32'h1234_5679, 32'h1234_5679, 32'h1234_5679, 32'h1234_5679,
               32'h1234_5678, 32'h1234_5679, 32'h1234_5679, 32'h1234_5679};
    cur[1] = '{default: 32'hA5A5_5A5A};
    stream(2);
    verify(2, "R4 ties");
  endtask

  task automatic t_back_to_back;
    // R5: node 2 smallest in the first value, largest in the second.
    cur[0] = '{32'h9000_0000, 32'h8000_0000, 32'h0000_0001, 32'h7000_0000,
               32'h9000_0000, 32'h8800_0000, 32'h9900_0000, 32'hA000_0000};
    cur[1] = '{32'h0500_0000, 32'h0600_0000, 32'hFFFF_FFFF, 32'h0300_0000,
               32'h0700_0000, 32'h0400_0000, 32'h0800_0000, 32'h0900_0000};
    stream(2);
    verify(2, "R5 restart");
    chk(firstbad == 0, "R6 first marker b2b", firstbad, 0);
  endtask

  task automatic t_bounds;
    cur[0] = '{default: 32'hFFFF_FFFF};
    cur[1] = '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
               32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF};
    stream(2);
    verify(2, "R8 bounds");
  endtask

  initial begin
    rst_n = 1'b0;
    dig_valid = 1'b0;
    dig_first = 1'b0;
    local_dig = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    repeat (4) @(negedge clk);
    t_spread();
    t_msb_first();
    t_ties();
    t_back_to_back();
    t_bounds();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule